// File: doc/BRIEF.md
# Reload-Buffered 8-Bit PWM Compare Channel

This block is one compare channel of a counter array, used in pulse width modulation mode. A free-running counter outside the block presents its low byte and a timebase-enable pulse. Each pulse marks a cycle in which the counter advances by one. The channel turns its output on when the counter reaches the active compare byte and turns it off when the counter wraps from its all-ones value back to zero. One full counter cycle of 256 ticks is one PWM period.

Software writes the duty byte at any time through a small register write port. The active compare byte picks up that value only at the next counter wrap, so the output never shows a partial or doubled pulse while the duty is changing. Writes to the compare bytes also change the compare-enable bit. Writing the compare low byte disables comparison and writing the duty byte enables it again, so the usual sequence is low byte first and duty byte last. The output runs only while compare-enable and PWM-enable are both set.

Top module: `pwm8_compare`

## Requirements
- R1: On a tick whose counter value is one less than the active compare byte, the output goes high from the next cycle, so the output is high exactly while the counter shows values from the compare byte up to 0xFF.
- R2: On a tick with counter value 0xFF (the wrap to 0x00), the output goes low from the next cycle. If a compare match and a wrap coincide, the output is low.
- R3: On each wrap tick while the channel is active, the active compare byte is loaded from the duty byte. A duty write made partway through a period leaves that period unchanged and takes effect in the period that follows the next wrap.
- R4: A write with select 2 sets compare-enable from data bit 0 and PWM-enable from data bit 1. The channel is active only when both bits are 1. While it is inactive the output is held low and no reload takes place.
- R5: A write with select 0 loads the active compare byte and clears compare-enable, so the output drops low and stays low.
- R6: A write with select 1 loads the duty byte and sets compare-enable.
- R7: For a duty byte D from 1 to 255, the output is high for 256−D ticks of each 256-tick period. For D = 0, the output stays low.
- R8: Compare and wrap are evaluated only on timebase-enable cycles. On all other cycles, the output holds its value.
- R9: Reset clears the compare byte, the duty byte, both enable bits and the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 compare low byte, 1 duty byte, 2 mode bits |
| wrData | input | 8 | Write data |
| tickEn | input | 1 | Counter advances this cycle |
| cntLow | input | 8 | Counter low byte before the advance |
| pwmOut | output | 1 | PWM output |

## Verification
The hardest case to set up is showing that the block skips a reload while it is disabled. That cannot be observed directly, because the output is forced low in that state. The stimulus disables PWM, writes a new duty byte and lets one wrap go by. It then re-enables the channel partway through the next period and counts the high ticks before the next wrap. That count still matches the old compare byte, and only the period after it matches the new duty. A second case writes the duty byte partway through a measured period and checks that the new width shows up exactly one period later.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_DUTY = 2'd1,
    SEL_MODE = 2'd2
  } wrSel_e;

  typedef struct packed {
    logic loadLow;
    logic loadDuty;
    logic loadMode;
    logic reload;
    logic setOut;
    logic clrOut;
  } strobes_t;
endpackage

// File: rtl/pwm8_ctrl.sv
module pwm8_ctrl
  import pwm8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic             tickEn,
  input  logic [CNT_W-1:0] cntLow,
  input  logic [CNT_W-1:0] cmpLow,
  input  logic             active,
  output strobes_t         st
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cntNext;
  logic             wrapTick;
  logic             matchTick;

  // compare against the value the counter takes after this tick
  assign cntNext   = cntLow + CNT_W'(1);
  assign wrapTick  = tickEn && (cntLow == CNT_MAX);
  assign matchTick = tickEn && active && (cntNext == cmpLow);

  always_comb begin
    st          = '0;
    st.loadLow  = wrEn && (wrSel == SEL_LOW);
    st.loadDuty = wrEn && (wrSel == SEL_DUTY);
    st.loadMode = wrEn && (wrSel == SEL_MODE);
    st.reload   = wrapTick && active;
    st.setOut   = matchTick;
    st.clrOut   = wrapTick || !active;
  end
endmodule

// File: rtl/pwm8_dp.sv
module pwm8_dp
  import pwm8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobes_t         st,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cmpLow,
  output logic             active,
  output logic             pwmOut
);
  logic [CNT_W-1:0] duty;
  logic             cmpEn;
  logic             pwmEn;

  assign active = cmpEn && pwmEn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpLow <= '0;
      duty   <= '0;
      cmpEn  <= 1'b0;
      pwmEn  <= 1'b0;
      pwmOut <= 1'b0;
    end else begin
      if (st.loadLow)     cmpLow <= wrData;
      else if (st.reload) cmpLow <= duty;

      if (st.loadDuty) duty <= wrData;

      if (st.loadMode) begin
        cmpEn <= wrData[0];
        pwmEn <= wrData[1];
      end else if (st.loadLow) begin
        cmpEn <= 1'b0;
      end else if (st.loadDuty) begin
        cmpEn <= 1'b1;
      end

      if (st.clrOut)      pwmOut <= 1'b0;
      else if (st.setOut) pwmOut <= 1'b1;
    end
  end

  // R5: a low-byte write disables comparison
  a_r5_low_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
    st.loadLow |=> !cmpEn);
  // R6: a duty write enables comparison
  a_r6_duty_sets_en: assert property (@(posedge clk) disable iff (!rst_n)
    st.loadDuty |=> cmpEn);
  // R2: a wrap or an inactive channel forces the output low
  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    st.clrOut |=> !pwmOut);
  // R1: a match with no clear raises the output
  a_r1_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (st.setOut && !st.clrOut) |=> pwmOut);
  // R3: the wrap copies the duty byte into the compare byte
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (st.reload && !st.loadLow) |=> (cmpLow == $past(duty)));
endmodule

// File: rtl/pwm8_compare.sv
module pwm8_compare
  import pwm8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             tickEn,
  input  logic [CNT_W-1:0] cntLow,
  output logic             pwmOut
);
  strobes_t         st;
  logic [CNT_W-1:0] cmpLow;
  logic             active;

  pwm8_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .wrEn(wrEn), .wrSel(wrSel), .tickEn(tickEn), .cntLow(cntLow),
    .cmpLow(cmpLow), .active(active), .st(st)
  );

  pwm8_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .st(st), .wrData(wrData),
    .cmpLow(cmpLow), .active(active), .pwmOut(pwmOut)
  );

  // R8: with no tick and an active channel the output holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tickEn && active) |=> $stable(pwmOut));
  // R4: an inactive channel gives a low output
  a_r4_inactive_low: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !pwmOut);
  // R2: a wrap tick at the ports ends the high phase
  a_r2_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && cntLow == {CNT_W{1'b1}}) |=> !pwmOut);
endmodule

// File: tb/pwm8_compare_tb.sv
module pwm8_compare_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       tickEn;
  logic [7:0] cnt = 8'd0;
  logic [1:0] phase = 2'd0;
  int         tickDiv = 1;
  logic       pwmOut;
  int         nChecks = 0;
  int         nFails = 0;
  int         cycles = 0;

  always #4 clk = ~clk; // 125 MHz

  assign tickEn = (phase == 2'd0);
  always @(posedge clk) begin
    phase  <= (int'(phase) + 1 >= tickDiv) ? 2'd0 : phase + 2'd1;
    cnt    <= cnt + {7'd0, tickEn};
    cycles <= cycles + 1;
  end

  pwm8_compare dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .tickEn(tickEn), .cntLow(cnt), .pwmOut(pwmOut)
  );

  // duty byte, expected high ticks per period
  localparam logic [15:0] VEC [5] = '{
    {8'h01, 8'd255}, {8'h40, 8'd192}, {8'h80, 8'd128},
    {8'hFF, 8'd1},   {8'h00, 8'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCnt(input logic [7:0] v);
    do @(negedge clk); while (!(tickEn && cnt == v));
  endtask

  // measure one 256-tick period; optional duty write at tick index wAt
  task automatic measure(input int wAt, input logic [7:0] wVal,
                         output int hi, output int chg);
    int ticks;
    logic prevOut, prevTick;
    waitCnt(8'h00);
    hi = 0; chg = 0; ticks = 0; prevOut = pwmOut; prevTick = 1'b1;
    while (ticks < 256) begin
      wrEn = 1'b0;
      if (!prevTick && pwmOut != prevOut) chg++;
      if (tickEn) begin
        if (pwmOut) hi++;
        if (ticks == wAt) begin
          wrEn = 1'b1; wrSel = 2'd1; wrData = wVal;
        end
        ticks++;
      end
      prevOut = pwmOut; prevTick = tickEn;
      @(negedge clk);
    end
    wrEn = 1'b0;
  endtask

  initial begin
    wait (cycles > 150000);
    check(1'b0, "watchdog", cycles, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int hi, chg;
    repeat (5) @(negedge clk);
    check(pwmOut == 1'b0, "R9 reset output", int'(pwmOut), 0);
    rst_n = 1'b1;
    measure(-1, 8'h00, hi, chg);
    check(hi == 0, "R9 idle after reset", hi, 0);

    wr(2'd2, 8'h03);
    wr(2'd0, 8'h80);
    wr(2'd1, 8'h80);
    measure(-1, 8'h00, hi, chg);

    // table of duty values (R7, R1, R2)
    foreach (VEC[i]) begin
      wr(2'd1, VEC[i][15:8]);
      measure(-1, 8'h00, hi, chg);
      measure(-1, 8'h00, hi, chg);
      check(hi == int'(VEC[i][7:0]), "R7 R1 R2 high ticks", hi, int'(VEC[i][7:0]));
    end

    // R3: mid-period duty write takes effect one period later
    wr(2'd1, 8'h80);
    measure(-1, 8'h00, hi, chg);
    measure(16, 8'h40, hi, chg);
    check(hi == 128, "R3 current period unchanged", hi, 128);
    measure(-1, 8'h00, hi, chg);
    check(hi == 192, "R3 next period updated", hi, 192);

    // R8: slow timebase
    tickDiv = 3;
    measure(-1, 8'h00, hi, chg);
    measure(-1, 8'h00, hi, chg);
    check(hi == 192, "R8 slow tick high ticks", hi, 192);
    check(chg == 0, "R8 hold between ticks", chg, 0);
    tickDiv = 1;

    // R4: disabled channel, no reload
    wr(2'd1, 8'h80);
    measure(-1, 8'h00, hi, chg);
    measure(-1, 8'h00, hi, chg);
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h20);
    measure(-1, 8'h00, hi, chg);
    check(hi == 0, "R4 pwm disabled low", hi, 0);
    waitCnt(8'h05);
    wr(2'd2, 8'h03);
    hi = 0;
    do begin
      @(negedge clk);
      if (tickEn && pwmOut) hi++;
    end while (!(tickEn && cnt == 8'hFF));
    check(hi == 128, "R4 no reload while disabled", hi, 128);
    measure(-1, 8'h00, hi, chg);
    check(hi == 224, "R4 reload after enable", hi, 224);

    // R5: low-byte write drops the output
    wr(2'd1, 8'h80);
    measure(-1, 8'h00, hi, chg);
    waitCnt(8'hA0);
    check(pwmOut == 1'b1, "R5 output high before write", int'(pwmOut), 1);
    wr(2'd0, 8'h80);
    @(negedge clk);
    check(pwmOut == 1'b0, "R5 low write clears", int'(pwmOut), 0);
    measure(-1, 8'h00, hi, chg);
    check(hi == 0, "R5 stays disabled", hi, 0);

    // R6: duty write re-enables
    wr(2'd1, 8'h80);
    measure(-1, 8'h00, hi, chg);
    check(hi == 128, "R6 duty write enables", hi, 128);

    // R9: reset mid-run clears duty and compare
    waitCnt(8'hC0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(pwmOut == 1'b0, "R9 reset mid-run", int'(pwmOut), 0);
    rst_n = 1'b1;
    wr(2'd2, 8'h03);
    measure(-1, 8'h00, hi, chg);
    measure(-1, 8'h00, hi, chg);
    check(hi == 0, "R9 registers cleared", hi, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule